// File: doc/BRIEF.md
# Channel-Priority Interrupt Arbiter

This block sits behind an interrupt capture stage. It takes the vector of pending interrupt sources, up to 32 of them. Each source carries a programmable 8-bit channel number, and the channel number, not the source's position in the vector, decides its priority. Channel 0 is the most urgent and channel 31 the least. The channels fall into two groups. Channels 0 and 1 feed a fast host line. Channels 2 to 31 feed a normal host line.

For each host line the block searches the pending sources for the most urgent one in that line's channel group. It reports the winning source index and a valid flag, both registered. It also drives the host line itself, which is the valid flag gated by that host's enable bit. A small write port lets the system program the packed channel-map registers and the host enables. The host enables can be written as a whole word or set and cleared one at a time by host index.

Top module: `prio_chan_arb`

## Requirements
- R1: While `rst` is high and on the first edge after it, all outputs are 0. After reset, every channel-map byte holds 15 and both host enables are 0.
- R2: Write command op 0 writes `cfg_wdata_i` into channel-map register `cfg_addr_i`. In that register, bits 8j+7:8j hold the channel of source 4·addr+j. There are (NSRC+3)/4 registers, and a write to an address at or beyond that count changes nothing.
- R3: Among the pending sources whose channel lies in a host's group, the one with the numerically lowest channel wins.
- R4: When several such pending sources share the winning channel, the one with the lowest source index wins.
- R5: Channels 0 and 1 belong to the fast host (`fast_*`). Channels 2 to 31 belong to the normal host (`norm_*`).
- R6: A source whose channel byte is above 31 never wins either host.
- R7: `*_valid_o` and `*_src_o` show the result for the pending vector and configuration sampled at the previous clock edge. A configuration write becomes visible at the outputs one edge after the edge that captures it.
- R8: Write command op 1 loads both host enables from `cfg_wdata_i[1:0]`, with bit 0 for the fast host and bit 1 for the normal host. Writing 0 disables both hosts.
- R9: Write command op 2 sets, and op 3 clears, the enable of host number `cfg_wdata_i` (0 is fast, 1 is normal). A host number of 2 or more changes nothing.
- R10: A host line is high exactly when that host's valid flag is high and its enable is set. The valid flag and source index are reported whatever the enable. The source index is 0 whenever the valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NSRC | Pending vector from the capture stage |
| cfg_we_i | input | 1 | Write strobe for the configuration port |
| cfg_op_i | input | 2 | 0 map write, 1 host-enable word, 2 host set by index, 3 host clear by index |
| cfg_addr_i | input | 8 | Channel-map register number for op 0 |
| cfg_wdata_i | input | 32 | Write data |
| fast_irq_o | output | 1 | Fast host line |
| norm_irq_o | output | 1 | Normal host line |
| fast_valid_o | output | 1 | A fast-group source is pending |
| fast_src_o | output | 5 | Winning fast-group source index |
| norm_valid_o | output | 1 | A normal-group source is pending |
| norm_src_o | output | 5 | Winning normal-group source index |

## Verification
A change on `pend_i` shows up at the outputs one clock edge later. A configuration write shows up two edges after it is driven: one edge to store the new value and one to register the result. The bench drives every input on the falling edge. It samples on the falling edge after the edge where the result is due, and the expected value uses the pending vector and configuration model that were in force at that edge. One check samples just before a rising edge, to confirm that the outputs still show the previous pattern.

// File: rtl/prio_map_pkg.sv
package prio_map_pkg;

    localparam int MAX_SRC   = 32;
    localparam int SRC_W     = 5;
    localparam int CHAN_W    = 8;
    localparam int CHAN_LAST = 31;
    localparam int FAST_LAST = 1;
    localparam int NHOST     = 2;
    localparam int WORD_W    = 32;
    localparam int SRC_PER_W = WORD_W / CHAN_W;
    localparam int ADDR_W    = 8;
    localparam logic [CHAN_W-1:0] CHAN_RST = 8'd15;

    typedef enum logic [1:0] {
        OP_MAP_WR  = 2'd0,
        OP_HEN_WR  = 2'd1,
        OP_HEN_SET = 2'd2,
        OP_HEN_CLR = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } win_t;

    function automatic int map_regs(input int nsrc);
        return (nsrc + SRC_PER_W - 1) / SRC_PER_W;
    endfunction

    function automatic int host_lo(input int h);
        return (h == 0) ? 0 : FAST_LAST + 1;
    endfunction

    function automatic int host_hi(input int h);
        return (h == 0) ? FAST_LAST : CHAN_LAST;
    endfunction

endpackage

// File: rtl/prio_map_regs.sv
module prio_map_regs
    import prio_map_pkg::*;
#(
    parameter int NSRC = 32,
    localparam int NREG = map_regs(NSRC),
    localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  cfg_op_e                  op_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [WORD_W-1:0]        wdata_i,
    output logic [NREG*WORD_W-1:0]   map_flat_o,
    output logic [NHOST-1:0]         hen_o
);

    logic [WORD_W-1:0] map_q [NREG];
    logic [NHOST-1:0]  hen_q;
    logic              addr_ok;
    logic              host_ok;

    assign addr_ok = {24'd0, addr_i} < NREG;
    assign host_ok = wdata_i < NHOST;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) begin
                map_q[k] <= {SRC_PER_W{CHAN_RST}};
            end
            hen_q <= '0;
        end else if (we_i) begin
            unique case (op_i)
                OP_MAP_WR:  if (addr_ok) map_q[addr_i[AW-1:0]] <= wdata_i;
                OP_HEN_WR:  hen_q <= wdata_i[NHOST-1:0];
                OP_HEN_SET: if (host_ok) hen_q[wdata_i[0]] <= 1'b1;
                OP_HEN_CLR: if (host_ok) hen_q[wdata_i[0]] <= 1'b0;
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < NREG; k++) begin : g_flat
        assign map_flat_o[k*WORD_W +: WORD_W] = map_q[k];
    end

    assign hen_o = hen_q;

endmodule

// File: rtl/prio_host_pick.sv
module prio_host_pick
    import prio_map_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int LO   = 0,
    parameter int HI   = 1,
    localparam int NREG = map_regs(NSRC)
) (
    input  logic [NSRC-1:0]          pend_i,
    input  logic [NREG*WORD_W-1:0]   map_flat_i,
    output win_t                     win_o
);

    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [CHAN_W-1:0] ch;
        assign ch = map_flat_i[i*CHAN_W +: CHAN_W];
        if (LO == 0) begin : g_from_zero
            assign hit[i] = pend_i[i] && (ch <= CHAN_W'(HI));
        end else begin : g_from_lo
            assign hit[i] = pend_i[i] && (ch >= CHAN_W'(LO)) && (ch <= CHAN_W'(HI));
        end
    end

    always_comb begin
        logic [CHAN_W-1:0] best;
        best  = '1;
        win_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (hit[i] && (map_flat_i[i*CHAN_W +: CHAN_W] < best)) begin
                best        = map_flat_i[i*CHAN_W +: CHAN_W];
                win_o.valid = 1'b1;
                win_o.src   = SRC_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_chan_arb.sv
module prio_chan_arb
    import prio_map_pkg::*;
#(
    parameter int NSRC = 32,
    localparam int NREG = map_regs(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   pend_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_op_i,
    input  logic [7:0]        cfg_addr_i,
    input  logic [31:0]       cfg_wdata_i,
    output logic              fast_irq_o,
    output logic              norm_irq_o,
    output logic              fast_valid_o,
    output logic [4:0]        fast_src_o,
    output logic              norm_valid_o,
    output logic [4:0]        norm_src_o
);

    logic [NREG*WORD_W-1:0] map_flat;
    logic [NHOST-1:0]       hen;
    win_t                   win_d [NHOST];
    win_t                   win_q [NHOST];
    logic [NHOST-1:0]       line_q;

    prio_map_regs #(.NSRC(NSRC)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we_i       (cfg_we_i),
        .op_i       (cfg_op_e'(cfg_op_i)),
        .addr_i     (cfg_addr_i),
        .wdata_i    (cfg_wdata_i),
        .map_flat_o (map_flat),
        .hen_o      (hen)
    );

    for (genvar h = 0; h < NHOST; h++) begin : g_host
        prio_host_pick #(
            .NSRC (NSRC),
            .LO   (host_lo(h)),
            .HI   (host_hi(h))
        ) u_pick (
            .pend_i     (pend_i),
            .map_flat_i (map_flat),
            .win_o      (win_d[h])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int h = 0; h < NHOST; h++) begin
                win_q[h] <= '0;
            end
            line_q <= '0;
        end else begin
            for (int h = 0; h < NHOST; h++) begin
                win_q[h]  <= win_d[h];
                line_q[h] <= win_d[h].valid & hen[h];
            end
        end
    end

    assign fast_irq_o   = line_q[0];
    assign norm_irq_o   = line_q[1];
    assign fast_valid_o = win_q[0].valid;
    assign fast_src_o   = win_q[0].src;
    assign norm_valid_o = win_q[1].valid;
    assign norm_src_o   = win_q[1].src;

endmodule

// File: rtl/prio_chan_arb_chk.sv
module prio_chan_arb_chk
    import prio_map_pkg::*;
#(
    parameter int NSRC = 32,
    localparam int NREG = map_regs(NSRC)
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NSRC-1:0]         pend_i,
    input logic [NREG*WORD_W-1:0]  map_flat,
    input logic                    cfg_we_i,
    input logic [1:0]              cfg_op_i,
    input logic [31:0]             cfg_wdata_i,
    input logic                    fast_irq_o,
    input logic                    norm_irq_o,
    input logic                    fast_valid_o,
    input logic [4:0]              fast_src_o,
    input logic                    norm_valid_o,
    input logic [4:0]              norm_src_o
);

    logic [NSRC-1:0]        prev_pend;
    logic [NREG*WORD_W-1:0] prev_map;

    always_ff @(posedge clk) begin
        prev_pend <= pend_i;
        prev_map  <= map_flat;
    end

    function automatic int chan_of(input logic [4:0] s);
        return int'(prev_map[int'(s)*CHAN_W +: CHAN_W]);
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !fast_valid_o && !norm_valid_o && !fast_irq_o && !norm_irq_o);

    assert_fast_group_R5: assert property (@(posedge clk) disable iff (rst)
        fast_valid_o |-> prev_pend[fast_src_o] && (chan_of(fast_src_o) <= FAST_LAST));

    // R6: a winner on the normal line never carries a byte above 31
    assert_norm_group_R5: assert property (@(posedge clk) disable iff (rst)
        norm_valid_o |-> prev_pend[norm_src_o] && (chan_of(norm_src_o) > FAST_LAST)
                         && (chan_of(norm_src_o) <= CHAN_LAST));

    assert_fast_gated_R10: assert property (@(posedge clk) disable iff (rst)
        fast_irq_o |-> fast_valid_o);

    assert_norm_gated_R10: assert property (@(posedge clk) disable iff (rst)
        norm_irq_o |-> norm_valid_o);

    assert_idle_src_R10: assert property (@(posedge clk) disable iff (rst)
        (!fast_valid_o |-> fast_src_o == 5'd0) and (!norm_valid_o |-> norm_src_o == 5'd0));

    assert_disable_all_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we_i && cfg_op_i == 2'd1 && cfg_wdata_i[1:0] == 2'b00)
        |=> ##1 (!fast_irq_o && !norm_irq_o));

endmodule

bind prio_chan_arb prio_chan_arb_chk #(.NSRC(NSRC)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .pend_i       (pend_i),
    .map_flat     (map_flat),
    .cfg_we_i     (cfg_we_i),
    .cfg_op_i     (cfg_op_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .fast_irq_o   (fast_irq_o),
    .norm_irq_o   (norm_irq_o),
    .fast_valid_o (fast_valid_o),
    .fast_src_o   (fast_src_o),
    .norm_valid_o (norm_valid_o),
    .norm_src_o   (norm_src_o)
);

// File: tb/prio_chan_arb_tb.sv
`timescale 1ns/1ps
module prio_chan_arb_tb_top;

    localparam int NS = 32;
    localparam int NR = (NS + 3) / 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pend;
    logic        we;
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        f_irq, n_irq, f_val, n_val;
    logic [4:0]  f_src, n_src;

    int          chan_m [NS];
    logic [1:0]  hen_m;
    int          tests = 0;
    int          fails = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    prio_chan_arb #(.NSRC(NS)) dut_i (
        .clk(clk), .rst(rst), .pend_i(pend), .cfg_we_i(we), .cfg_op_i(op),
        .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .fast_irq_o(f_irq), .norm_irq_o(n_irq),
        .fast_valid_o(f_val), .fast_src_o(f_src),
        .norm_valid_o(n_val), .norm_src_o(n_src)
    );

    task automatic ref_pick(input logic [31:0] p, input int lo, input int hi,
                            output logic v, output logic [4:0] s);
        int best = 1000;
        v = 1'b0;
        s = 5'd0;
        for (int i = 0; i < NS; i++) begin
            if (p[i] && chan_m[i] >= lo && chan_m[i] <= hi && chan_m[i] < best) begin
                best = chan_m[i];
                v = 1'b1;
                s = 5'(i);
            end
        end
    endtask

    task automatic check(input string tag, input logic [31:0] p);
        logic fv, nv, fi, ni;
        logic [4:0] fs, ns;
        ref_pick(p, 0, 1, fv, fs);
        ref_pick(p, 2, 31, nv, ns);
        fi = fv & hen_m[0];
        ni = nv & hen_m[1];
        tests++;
        if ({f_val, f_src, n_val, n_src, f_irq, n_irq} !== {fv, fs, nv, ns, fi, ni}) begin
            fails++;
            $display("FAIL %s pend=%h got fv=%0b fs=%0d nv=%0b ns=%0d fi=%0b ni=%0b exp fv=%0b fs=%0d nv=%0b ns=%0d fi=%0b ni=%0b",
                     tag, p, f_val, f_src, n_val, n_src, f_irq, n_irq, fv, fs, nv, ns, fi, ni);
        end
    endtask

    task automatic cfg(input logic [1:0] o, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; op = o; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        case (o)
            2'd0: if (int'(a) < NR) for (int j = 0; j < 4; j++) chan_m[int'(a)*4+j] = int'(d[j*8 +: 8]);
            2'd1: hen_m = d[1:0];
            2'd2: if (d < 2) hen_m[d[0]] = 1'b1;
            default: if (d < 2) hen_m[d[0]] = 1'b0;
        endcase
        @(negedge clk);
    endtask

    task automatic apply(input string tag, input logic [31:0] p);
        pend = p;
        @(negedge clk);
        check(tag, p);
    endtask

    task automatic fill_map(input int mode);
        for (int k = 0; k < NR; k++) begin
            logic [31:0] w;
            for (int j = 0; j < 4; j++) begin
                int s = k*4 + j;
                case (mode)
                    0: w[j*8 +: 8] = 8'((s*13 + 5) % 37);
                    1: w[j*8 +: 8] = 8'd4;
                    2: w[j*8 +: 8] = 8'(32 + (s % 4) * 70);
                    default: w[j*8 +: 8] = 8'((s % 3 == 0) ? (s % 2) : 2 + (s % 3));
                endcase
            end
            cfg(2'd0, 8'(k), w);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr, old;
        for (int i = 0; i < NS; i++) chan_m[i] = 15;
        hen_m = 2'b00;
        rst = 1'b1; pend = 32'hFFFF_FFFF; we = 1'b0; op = 2'd0; addr = 8'd0; wdata = 32'd0;
        repeat (3) @(negedge clk);
        check("R1 in reset", 32'd0);
        rst = 1'b0;
        check("R1 reset exit", 32'd0);
        @(negedge clk);
        check("R1 R10 default channel 15, hosts off", pend);

        cfg(2'd1, 8'd0, 32'd3);
        for (int i = 0; i < NS; i++) apply("R5 default map single source", 32'd1 << i);

        fill_map(0);
        lfsr = 32'hACE1_2357;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply((n % 2) ? "R3 R6 sparse sweep" : "R2 R5 dense sweep",
                  (n % 2) ? (lfsr & (lfsr >> 9)) : lfsr);
        end

        fill_map(3);
        for (int n = 0; n < 64; n++) apply("R3 R5 mixed groups", 32'(n) * 32'h0411_3A05);

        fill_map(1);
        for (int i = 0; i < NS; i++) apply("R4 tie lowest index", 32'hFFFF_FFFF << i);

        cfg(2'd0, 8'(NR), 32'h0000_0000);
        apply("R2 out-of-range address ignored", 32'h0000_0F00);

        fill_map(2);
        apply("R6 unmapped bytes never win", 32'hFFFF_FFFF);

        fill_map(0);
        pend = 32'h0000_00F1;
        cfg(2'd1, 8'd0, 32'd0);
        check("R8 word write 0 disables hosts", pend);
        cfg(2'd2, 8'd0, 32'd0);
        check("R9 set fast by index", pend);
        cfg(2'd2, 8'd0, 32'd5);
        check("R9 set index 5 ignored", pend);
        cfg(2'd3, 8'd0, 32'd7);
        check("R9 clear index 7 ignored", pend);
        cfg(2'd2, 8'd0, 32'd1);
        check("R9 set normal by index", pend);
        cfg(2'd3, 8'd0, 32'd0);
        check("R9 clear fast by index", pend);
        cfg(2'd1, 8'd0, 32'd1);
        check("R8 word write fast only", pend);
        cfg(2'd1, 8'd0, 32'd3);

        old = pend;
        @(negedge clk);
        pend = 32'h8000_0000;
        #1;
        check("R7 output holds before edge", old);
        @(negedge clk);
        check("R7 output updates after one edge", pend);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule